// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block picks one interrupt among up to fifteen pending sources and gives the vector address the CPU reads its handler address from. It works for a 16-bit processor. Each source has a fixed priority number. Source index `i` has priority `16 + i`. Priority 31 is held for reset. Every source belongs to one of three gating classes, and the class decides which enables can block it.

The block also watches instruction fetches. A fetch strobe whose address falls outside every legal code window raises a reset-request pulse. That pulse takes precedence over any interrupt in the same cycle. After reset is released, the block reads the word stored in the reset vector once. If that word is all ones, the device is blank, and the block holds a force-deepest-sleep output until the next reset.

All outputs are registered. Each result shows on the outputs one clock edge after the inputs that cause it.

Top module: `ivc_top`

## Requirements
- R1: While reset is asserted and just after it, `irq_req`, `rst_req` and `deep_sleep` are 0 and `vec_addr` is 16'hFFFE.
- R2: A source of the maskable class (class code 0, the default for indices 0..12) is granted only when its pending bit, its enable bit and `gie` are all 1.
- R3: A source of the enable-only class (class code 1, default index 14) is blocked by its own enable bit and is granted regardless of `gie`.
- R4: A source of the non-maskable class (class code 2, default index 13) is granted whenever its pending bit is 1, whatever its enable bit and `gie` are.
- R5: When several gated sources are requesting, the highest index wins. `vec_addr` becomes 16'hFFC0 + 2*(16 + index), and `irq_req` is 1, one clock edge after the inputs.
- R6: Whenever `irq_req` is 1, `vec_addr` lies in 16'hFFE0..16'hFFFC and is even. The unused vector area 16'hFFC0..16'hFFDE is never produced.
- R7: A fetch strobe with an address in 16'h0000..16'h01FF makes `rst_req` 1 one edge later.
- R8: A fetch strobe with an address outside all legal windows also makes `rst_req` 1. By default the legal windows are RAM 16'h0200..16'h05FF, boot 16'h0C00..16'h0FFF, info 16'h1000..16'h10FF and code 16'h8000..16'hFFFF. Fetches inside these windows do not raise it.
- R9: `rst_req` is never high on two consecutive cycles. An illegal fetch seen while `rst_req` is high is ignored.
- R10: In a cycle where `rst_req` is 1, `irq_req` is 0 and `vec_addr` is 16'hFFFE, even if sources are requesting.
- R11: On the first clock edge after reset is released, `boot_word` is sampled. If it equals 16'hFFFF, `deep_sleep` becomes 1 and stays 1 until the next reset. Otherwise it stays 0.
- R12: With no gated request and no reset request, `irq_req` is 0 and `vec_addr` is 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | 15 | Pending flag per source, index i has priority 16+i |
| src_en | input | 15 | Individual enable per source |
| gie | input | 1 | Global interrupt enable |
| fetch_addr | input | 16 | Address of the current instruction fetch |
| fetch_vld | input | 1 | Fetch strobe, qualifies `fetch_addr` |
| boot_word | input | 16 | Word read from the reset vector location |
| vec_addr | output | 16 | Selected vector address |
| irq_req | output | 1 | Interrupt request to the CPU |
| rst_req | output | 1 | One-cycle reset request after an illegal fetch |
| deep_sleep | output | 1 | Force deepest low-power mode, blank device |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. The bench drives inputs on the falling edge and samples on the next falling edge, which leaves one register stage between them. For the blank-device check, reset is released on a falling edge and `deep_sleep` is read one falling edge later. The word is then changed, and the bench confirms that the flag keeps its value. For the reset pulse, an illegal fetch is held over several edges, and the bench checks the high-low-high pattern edge by edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        CLS_MASK   = 2'd0,
        CLS_ENONLY = 2'd1,
        CLS_NMI    = 2'd2
    } src_class_e;

    localparam logic [ADDR_W-1:0] VEC_BASE   = 16'hFFC0;
    localparam logic [ADDR_W-1:0] RST_VEC    = 16'hFFFE;
    localparam int                FIRST_PRIO = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] vec;
        logic              irq;
        logic              rst;
        logic              sleep;
        logic              booted;
    } ivc_state_t;

endpackage

// File: rtl/ivc_src_gate.sv
module ivc_src_gate #(
    parameter int                  NUM_SRC   = 15,
    parameter logic [2*NUM_SRC-1:0] SRC_CLASS = '0
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic               gie,
    output logic [NUM_SRC-1:0] gated
);
    import ivc_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [1:0] CLS = SRC_CLASS[2*g +: 2];
        if (CLS == CLS_NMI) begin : g_nmi
            assign gated[g] = pend[g];
        end else if (CLS == CLS_ENONLY) begin : g_enonly
            assign gated[g] = pend[g] & en[g];
        end else begin : g_mask
            assign gated[g] = pend[g] & en[g] & gie;
        end
    end

    // An idle source never requests, whatever its class
    always_comb begin
        assert_no_phantom_R2: assert ((gated & ~pend) == '0);
    end

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int NUM_SRC = 15,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // The winner is requesting, and nothing above it is
    always_comb begin
        if (any) begin
            assert_winner_valid_R5: assert (req[idx]);
            assert_winner_top_R5: assert ((req >> idx) == 1);
        end
    end

endmodule

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard #(
    parameter logic [15:0] RAM_LO   = 16'h0200,
    parameter logic [15:0] RAM_HI   = 16'h05FF,
    parameter logic [15:0] BOOT_LO  = 16'h0C00,
    parameter logic [15:0] BOOT_HI  = 16'h0FFF,
    parameter logic [15:0] INFO_LO  = 16'h1000,
    parameter logic [15:0] INFO_HI  = 16'h10FF,
    parameter logic [15:0] CODE_LO  = 16'h8000
) (
    input  logic [15:0] addr,
    output logic        illegal
);
    logic in_ram, in_boot, in_info, in_code;

    always_comb begin
        in_ram  = (addr >= RAM_LO)  && (addr <= RAM_HI);
        in_boot = (addr >= BOOT_LO) && (addr <= BOOT_HI);
        in_info = (addr >= INFO_LO) && (addr <= INFO_HI);
        in_code = (addr >= CODE_LO);
        illegal = !(in_ram || in_boot || in_info || in_code);
    end

    // The register page below the RAM window can never hold code
    always_comb begin
        assert_regpage_illegal_R7: assert (!(addr < 16'h0200) || illegal);
    end

endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
    parameter int                   NUM_SRC   = 15,
    parameter logic [2*NUM_SRC-1:0] SRC_CLASS = {2'd1, 2'd2, {(2*NUM_SRC-4){1'b0}}},
    parameter logic [15:0]          RAM_HI    = 16'h05FF,
    parameter logic [15:0]          CODE_LO   = 16'h8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               gie,
    input  logic [15:0]        fetch_addr,
    input  logic               fetch_vld,
    input  logic [15:0]        boot_word,
    output logic [15:0]        vec_addr,
    output logic               irq_req,
    output logic               rst_req,
    output logic               deep_sleep
);
    import ivc_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] gated;
    logic               any_req;
    logic [IDX_W-1:0]   win_idx;
    logic               fetch_bad;
    logic [15:0]        win_vec;
    ivc_state_t         st_d, st_q;

    ivc_src_gate #(.NUM_SRC(NUM_SRC), .SRC_CLASS(SRC_CLASS)) u_gate (
        .pend (src_pend),
        .en   (src_en),
        .gie  (gie),
        .gated(gated)
    );

    ivc_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .req(gated),
        .any(any_req),
        .idx(win_idx)
    );

    ivc_fetch_guard #(.RAM_HI(RAM_HI), .CODE_LO(CODE_LO)) u_guard (
        .addr   (fetch_addr),
        .illegal(fetch_bad)
    );

    always_comb begin
        win_vec = VEC_BASE + ((16'(FIRST_PRIO) + 16'(win_idx)) << 1);
        st_d        = st_q;
        st_d.booted = 1'b1;
        if (!st_q.booted) begin
            st_d.sleep = (boot_word == 16'hFFFF);
        end
        st_d.rst = fetch_vld && fetch_bad && !st_q.rst;
        if (st_d.rst) begin
            st_d.irq = 1'b0;
            st_d.vec = RST_VEC;
        end else if (any_req) begin
            st_d.irq = 1'b1;
            st_d.vec = win_vec;
        end else begin
            st_d.irq = 1'b0;
            st_d.vec = RST_VEC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vec: RST_VEC, irq: 1'b0, rst: 1'b0, sleep: 1'b0, booted: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_addr   = st_q.vec;
    assign irq_req    = st_q.irq;
    assign rst_req    = st_q.rst;
    assign deep_sleep = st_q.sleep;

    assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_rst_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!irq_req && vec_addr == 16'hFFFE));

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_addr >= 16'hFFE0 && vec_addr <= 16'hFFFC && !vec_addr[0]));

    assert_regpage_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_addr < 16'h0200 && !rst_req) |=> rst_req);

    assert_code_fetch_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_addr >= CODE_LO) |=> !rst_req);

    assert_sleep_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.booted |=> $stable(deep_sleep));

    assert_idle_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !rst_req) |-> vec_addr == 16'hFFFE);

endmodule

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] src_pend = '0;
    logic [14:0] src_en = '0;
    logic        gie = 1'b0;
    logic [15:0] fetch_addr = 16'h8000;
    logic        fetch_vld = 1'b0;
    logic [15:0] boot_word = 16'h8000;
    logic [15:0] vec_addr;
    logic        irq_req, rst_req, deep_sleep;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ivc_top dut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en), .gie(gie),
        .fetch_addr(fetch_addr), .fetch_vld(fetch_vld), .boot_word(boot_word),
        .vec_addr(vec_addr), .irq_req(irq_req), .rst_req(rst_req), .deep_sleep(deep_sleep)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        src_pend = '0; src_en = '0; gie = 1'b0; fetch_vld = 1'b0; fetch_addr = 16'h8000;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq in reset", 16'(irq_req), 16'd0);
        chk("R1 rst in reset", 16'(rst_req), 16'd0);
        chk("R1 sleep in reset", 16'(deep_sleep), 16'd0);
        chk("R1 vec in reset", vec_addr, 16'hFFFE);
        rst_n = 1'b1;
        step();
        chk("R1 sleep after release", 16'(deep_sleep), 16'd0);
        chk("R12 idle irq", 16'(irq_req), 16'd0);
        chk("R12 idle vec", vec_addr, 16'hFFFE);
    endtask

    task automatic t_mask();
        src_pend = 15'h0020; src_en = 15'h0020; gie = 1'b0; step();
        chk("R2 gie low blocks", 16'(irq_req), 16'd0);
        gie = 1'b1; src_en = '0; step();
        chk("R2 en low blocks", 16'(irq_req), 16'd0);
        src_en = 15'h0020; step();
        chk("R2 granted irq", 16'(irq_req), 16'd1);
        chk("R2 vec idx5", vec_addr, 16'hFFEA);
        src_pend = 15'h0001; src_en = 15'h0001; step();
        chk("R5 vec idx0", vec_addr, 16'hFFE0);
        idle_inputs(); step();
        chk("R12 back idle", vec_addr, 16'hFFFE);
    endtask

    task automatic t_enonly();
        src_pend = 15'h4000; src_en = '0; gie = 1'b1; step();
        chk("R3 en low blocks", 16'(irq_req), 16'd0);
        src_en = 15'h4000; gie = 1'b0; step();
        chk("R3 gie ignored irq", 16'(irq_req), 16'd1);
        chk("R3 vec idx14", vec_addr, 16'hFFFC);
        idle_inputs(); step();
    endtask

    task automatic t_nmi();
        src_pend = 15'h2000; src_en = '0; gie = 1'b0; step();
        chk("R4 nmi irq", 16'(irq_req), 16'd1);
        chk("R4 nmi vec idx13", vec_addr, 16'hFFFA);
        idle_inputs(); step();
    endtask

    task automatic t_prio();
        src_pend = 15'h0C21; src_en = 15'h0FFF; gie = 1'b1; step();
        chk("R5 idx11 wins", vec_addr, 16'hFFF6);
        src_pend = 15'h6C21; src_en = 15'h0FFF; step();
        chk("R5 idx13 wins over 11", vec_addr, 16'hFFFA);
        src_en = 15'h4FFF; step();
        chk("R5 idx14 wins", vec_addr, 16'hFFFC);
        gie = 1'b0; src_pend = 15'h0C21; step();
        chk("R5 all masked", 16'(irq_req), 16'd0);
        idle_inputs(); step();
    endtask

    task automatic t_fetch();
        logic [15:0] bad [4] = '{16'h0000, 16'h01FF, 16'h0700, 16'h4000};
        logic [15:0] good[5] = '{16'h0200, 16'h05FF, 16'h0C00, 16'h10FF, 16'hFFFE};
        foreach (bad[i]) begin
            fetch_addr = bad[i]; fetch_vld = 1'b1; step();
            chk(i < 2 ? "R7 regpage fetch" : "R8 unused fetch", 16'(rst_req), 16'd1);
            fetch_vld = 1'b0; step();
        end
        foreach (good[i]) begin
            fetch_addr = good[i]; fetch_vld = 1'b1; step();
            chk("R8 legal fetch", 16'(rst_req), 16'd0);
        end
        fetch_addr = 16'h0100; fetch_vld = 1'b0; step();
        chk("R7 no strobe no reset", 16'(rst_req), 16'd0);
        idle_inputs(); step();
    endtask

    task automatic t_pulse();
        fetch_addr = 16'h0100; fetch_vld = 1'b1; step();
        chk("R9 first pulse", 16'(rst_req), 16'd1);
        step();
        chk("R9 ignored while high", 16'(rst_req), 16'd0);
        step();
        chk("R9 next pulse", 16'(rst_req), 16'd1);
        idle_inputs(); step();
        chk("R9 released", 16'(rst_req), 16'd0);
    endtask

    task automatic t_override();
        src_pend = 15'h2000; fetch_addr = 16'h0050; fetch_vld = 1'b1; step();
        chk("R10 rst high", 16'(rst_req), 16'd1);
        chk("R10 irq held off", 16'(irq_req), 16'd0);
        chk("R10 vec reset", vec_addr, 16'hFFFE);
        fetch_vld = 1'b0; step();
        chk("R10 irq after", 16'(irq_req), 16'd1);
        chk("R10 vec after", vec_addr, 16'hFFFA);
        idle_inputs(); step();
    endtask

    task automatic t_blank();
        rst_n = 1'b0; boot_word = 16'hFFFF; step();
        chk("R11 sleep low in reset", 16'(deep_sleep), 16'd0);
        rst_n = 1'b1; step();
        chk("R11 blank sleep", 16'(deep_sleep), 16'd1);
        boot_word = 16'h8000; step(); step();
        chk("R11 sleep sticky", 16'(deep_sleep), 16'd1);
        rst_n = 1'b0; step();
        chk("R11 reset clears", 16'(deep_sleep), 16'd0);
        boot_word = 16'hFFFE; rst_n = 1'b1; step();
        chk("R11 programmed no sleep", 16'(deep_sleep), 16'd0);
        boot_word = 16'hFFFF; step();
        chk("R11 late word ignored", 16'(deep_sleep), 16'd0);
    endtask

    initial begin
        t_reset();
        t_mask();
        t_enonly();
        t_nmi();
        t_prio();
        t_fetch();
        t_pulse();
        t_override();
        t_blank();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule